// File: doc/BRIEF.md
# Serial Boot Image Transmitter

This block boots a target processor over a three-wire synchronous serial link: a bit clock, a data line and a frame strobe. A boot image sits in a small word memory on the host side, and the block reads it through a combinational read port. When `start` arrives, the block first steps the target through its reset sequence. It pulls reset low, then releases it, then raises the line that selects the serial boot path. After that it walks the image by itself.

The first two words of the image describe the target's external bus. A serial boot has no use for them, so they are skipped. From the third word onward the image is a chain of sections. Each section is a length word, then a load-address word, then exactly that many data words. A length word of zero is still transmitted, and it closes the boot.

A runtime divider sets how many system clocks each half of the bit clock lasts. If the walk would read beyond the end of the memory, the block stops and flags an error.

Top module: `boot_streamer`

## Requirements
- R1: Every transmitted word is 32 bits, sent most significant bit first. The receiver takes one bit on each rising edge of `ser_clk` that follows the frame strobe.
- R2: `ser_frame` is high for exactly two clock phases (2 × half-period system clocks) before each word, with one `ser_clk` rising edge inside that window. It falls together with the falling edge of `ser_clk` at which the first data bit is driven.
- R3: `ser_data` changes only while `ser_clk` is low or falling. It never changes at a rising edge or while `ser_clk` stays high.
- R4: Memory words 0 and 1 are never read for transmission. The first word sent is the one at memory address 2.
- R5: After the header the block repeats one pattern: send a length word L, and if L is nonzero send the next word as the address and then exactly L data words, in memory order.
- R6: After a zero length word has been fully sent, `done` goes to 1 and `busy` goes to 0. `done` and `error` are cleared by the next accepted start.
- R7: On start, `tgt_reset_n` goes to 0 for one phase and then rises. `boot_int` rises exactly one phase later. `ser_clk`, `ser_data` and `ser_frame` stay 0 whenever `boot_int` is 0.
- R8: `half_period` is captured at start and gives the phase length in system clocks. A value of 0 behaves as 1. Every bit period is twice the phase length, and later changes to the input have no effect until the next start.
- R9: A `start` pulse while `busy` is 1 is ignored. The stream in progress continues unchanged.
- R10: If a word is needed from an address at or beyond DEPTH, nothing more is sent. `error` goes to 1, `busy` goes to 0 and `done` stays 0.
- R11: After reset, `tgt_reset_n`, `boot_int`, the serial lines, `busy`, `done` and `error` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a boot |
| half_period | input | DIV_W | Phase length in system clocks (0 treated as 1) |
| mem_addr | output | $clog2(DEPTH) | Image memory read address |
| mem_rdata | input | 32 | Image word at `mem_addr` (combinational) |
| tgt_reset_n | output | 1 | Target reset, active low |
| boot_int | output | 1 | Target boot-select interrupt line |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data |
| ser_frame | output | 1 | Frame strobe, active high |
| busy | output | 1 | Boot in progress |
| done | output | 1 | Terminating zero length word has been sent |
| error | output | 1 | Image walk ran past the memory depth |

## Verification
The bench builds the block with DEPTH = 16 and DIV_W = 4. A 16-word image is small enough that a single twelve-word section runs the walk off the end of memory, so the overflow stop can be reached in a short run. Half-period values of 0, 1 and 3 are exercised, which covers the zero-means-one rule and a phase longer than one clock. A change to `half_period` in the middle of a boot shows that the value is captured at start. The serial lines are decoded by an independent receiver model that samples on rising edges, and that model also times the frame strobe and the bit periods.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W   = 32;
  localparam int HDR_WORDS = 2;
  localparam int PHASES   = 2 + 2 * WORD_W;   // two frame phases + two per bit

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_REL, ST_INT, ST_LOAD, ST_SEND
  } bst_e;

  typedef enum logic [1:0] {WK_LEN, WK_ADDR, WK_DATA} wkind_e;

  // phase index -> bit position carried on the data line
  function automatic int bit_of_phase(input int ph);
    return (WORD_W - 1) - ((ph - 2) / 2);
  endfunction
endpackage

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] h);
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  assign tick = en && (cnt == eff_half(half) - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/boot_word_tx.sv
module boot_word_tx
  import boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              active,
  input  logic              tick,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_frame,
  output logic              word_done
);
  localparam int PH_W = $clog2(PHASES);
  localparam int IW   = $clog2(WORD_W);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [PH_W-1:0]   phase;
  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     bidx;

  assign bidx      = IW'(bit_of_phase(int'(phase)));
  assign ser_frame = active && (phase < PH_W'(2));
  assign ser_clk   = active && phase[0];
  assign ser_data  = active && !(phase < PH_W'(2)) && word_q[bidx];
  assign word_done = active && tick && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      word_q <= '0;
    end else if (load) begin
      phase  <= '0;
      word_q <= word_in;
    end else if (active && tick) begin
      phase <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/boot_walker.sv
module boot_walker
  import boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              load,
  input  logic [WORD_W-1:0] rdata,
  input  logic              word_done,
  output logic              last
);
  wkind_e            kind;
  logic [WORD_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= WK_LEN;
      remaining <= '0;
      last      <= 1'b0;
    end else if (restart) begin
      kind <= WK_LEN;
      last <= 1'b0;
    end else if (load && kind == WK_LEN) begin
      remaining <= rdata;
      last      <= (rdata == '0);
    end else if (word_done && !last) begin
      unique case (kind)
        WK_LEN:  kind <= WK_ADDR;
        WK_ADDR: kind <= WK_DATA;
        default: begin
          remaining <= remaining - WORD_W'(1);
          if (remaining == WORD_W'(1)) kind <= WK_LEN;
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_streamer.sv
module boot_streamer
  import boot_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DIV_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  half_period,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tgt_reset_n,
  output logic              boot_int,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_frame,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int PW = AW + 1;

  bst_e             state;
  logic [PW-1:0]    ptr;
  logic [DIV_W-1:0] half_q;
  logic             tick, word_done, last, ptr_ovf;
  logic             load_word, accept, timer_en, sending;

  assign accept    = (state == ST_IDLE) && start;
  assign ptr_ovf   = (ptr >= PW'(DEPTH));
  assign load_word = (state == ST_LOAD) && !ptr_ovf;
  assign sending   = (state == ST_SEND);
  assign timer_en  = (state != ST_IDLE) && (state != ST_LOAD);
  assign busy      = (state != ST_IDLE);
  assign mem_addr  = ptr[AW-1:0];

  boot_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .half(half_q), .tick(tick)
  );

  boot_word_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(load_word), .word_in(mem_rdata),
    .active(sending), .tick(tick), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_frame(ser_frame), .word_done(word_done)
  );

  boot_walker u_walk (
    .clk(clk), .rst_n(rst_n), .restart(accept), .load(load_word),
    .rdata(mem_rdata), .word_done(word_done), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ptr         <= '0;
      half_q      <= '0;
      tgt_reset_n <= 1'b0;
      boot_int    <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          half_q      <= half_period;
          ptr         <= PW'(HDR_WORDS);
          done        <= 1'b0;
          error       <= 1'b0;
          tgt_reset_n <= 1'b0;
          boot_int    <= 1'b0;
          state       <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          tgt_reset_n <= 1'b1;
          state       <= ST_REL;
        end
        ST_REL: if (tick) begin
          boot_int <= 1'b1;
          state    <= ST_INT;
        end
        ST_INT: if (tick) state <= ST_LOAD;
        ST_LOAD: begin
          if (ptr_ovf) begin
            error <= 1'b1;
            state <= ST_IDLE;
          end else begin
            ptr   <= ptr + PW'(1);
            state <= ST_SEND;
          end
        end
        default: if (word_done) begin
          if (last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_LOAD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_streamer_chk.sv
module boot_streamer_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          tgt_reset_n,
  input logic          boot_int,
  input logic          ser_clk,
  input logic          ser_data,
  input logic          ser_frame,
  input logic [AW-1:0] mem_addr,
  input logic          load_word,
  input logic          word_done
);
  p_quiet_before_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_int |-> (!ser_clk && !ser_data && !ser_frame));

  p_int_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_int) |-> tgt_reset_n);

  p_frame_drop_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_frame) |-> !ser_clk);

  p_data_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  p_header_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_word |-> ({1'b0, mem_addr} >= (AW+1)'(2)));

  p_done_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(word_done) && !busy));

  p_error_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (!busy && !done));
endmodule

bind boot_streamer boot_streamer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .tgt_reset_n(tgt_reset_n), .boot_int(boot_int), .ser_clk(ser_clk),
  .ser_data(ser_data), .ser_frame(ser_frame), .mem_addr(mem_addr),
  .load_word(load_word), .word_done(word_done)
);

// File: tb/sim_boot_streamer.sv
`timescale 1ns/1ps
module sim_boot_streamer;
  localparam int DEPTH = 16;
  localparam int DIV_W = 4;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, start = 0;
  logic [DIV_W-1:0] half_period = '0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;
  logic tgt_reset_n, boot_int, ser_clk, ser_data, ser_frame, busy, done, error;
  logic [31:0] img [0:DEPTH-1];

  assign mem_rdata = img[mem_addr];
  always #2 clk = ~clk;

  boot_streamer #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tgt_reset_n(tgt_reset_n),
    .boot_int(boot_int), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_frame(ser_frame), .busy(busy), .done(done), .error(error)
  );

  int nvec = 0, nbad = 0;
  int cyc = 0, h_exp = 1;
  int rx_n = 0, bits = 0, fhi = 0, last_rise = 0;
  int data_bad = 0, frame_bad = 0, gap_bad = 0, quiet_bad = 0;
  int t_start = 0, t_rst = 0, t_int = 0;
  logic rxing = 0, p_clk = 0, p_data = 0, p_frame = 0, p_rst = 0, p_int = 0;
  logic [31:0] sh = '0;
  logic [31:0] rx [0:31];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent receiver model, samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_clk && ser_data != p_data) data_bad++;
      if (!boot_int && (ser_clk || ser_data || ser_frame)) quiet_bad++;
      if (ser_frame) fhi++;
      else if (p_frame) begin
        if (fhi != 2 * h_exp || ser_clk) frame_bad++;
        fhi = 0;
      end
      if (ser_clk && !p_clk) begin
        if (ser_frame) begin
          rxing = 1; bits = 0; last_rise = cyc;
        end else if (rxing) begin
          if (cyc - last_rise != 2 * h_exp) gap_bad++;
          last_rise = cyc;
          sh = {sh[30:0], ser_data};
          bits++;
          if (bits == 32) begin
            if (rx_n < 32) rx[rx_n] = sh;
            rx_n++;
            rxing = 0;
          end
        end
      end
      if (tgt_reset_n && !p_rst) t_rst = cyc;
      if (boot_int && !p_int) t_int = cyc;
    end
    p_clk = ser_clk; p_data = ser_data; p_frame = ser_frame;
    p_rst = tgt_reset_n; p_int = boot_int;
  end

  // watchdog
  initial begin
    #(4 * 150000);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = 32'hDEAD0000 | i;
  endtask

  task automatic launch(input int h);
    rx_n = 0; rxing = 0; data_bad = 0; frame_bad = 0; gap_bad = 0; quiet_bad = 0; fhi = 0;
    h_exp = (h == 0) ? 1 : h;
    @(negedge clk);
    half_period = DIV_W'(h);
    start = 1;
    t_start = cyc;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic check_stream(input int nexp, input string tag);
    chk(rx_n == nexp, {tag, " R5 word count"}, rx_n, nexp);
    for (int i = 0; i < nexp && i < 32; i++)
      chk(rx[i] == img[2 + i], {tag, " R1 word value"}, rx[i], img[2 + i]);
    chk(data_bad == 0, {tag, " R3 data change while clock high"}, data_bad, 0);
    chk(frame_bad == 0, {tag, " R2 frame width/edge"}, frame_bad, 0);
    chk(gap_bad == 0, {tag, " R8 bit period"}, gap_bad, 0);
    chk(quiet_bad == 0, {tag, " R7 lines quiet before boot_int"}, quiet_bad, 0);
    chk(t_rst > t_start && (t_int - t_rst) == h_exp, {tag, " R7 release/int spacing"},
        t_int - t_rst, h_exp);
  endtask

  task automatic t_reset_state();
    chk({tgt_reset_n, boot_int, ser_clk, ser_data, ser_frame, busy, done, error} == 8'h00,
        "R11 reset outputs", {tgt_reset_n, boot_int, ser_clk, ser_data, ser_frame, busy, done, error}, 0);
  endtask

  task automatic t_basic();
    clear_img();
    img[0] = 32'h8; img[1] = 32'h10f8;
    img[2] = 1; img[3] = 32'h00809802; img[4] = 0;
    img[5] = 3; img[6] = 32'h00809900; img[7] = 32'hA5C3_0F81;
    img[8] = 32'h8000_0001; img[9] = 32'h1234_5678; img[10] = 0;
    launch(1);
    wait_end();
    check_stream(9, "basic");
    chk(rx[0] != img[0] && rx[0] != img[1], "R4 header not sent", rx[0], img[2]);
    chk(done && !error && !busy, "R6 done raised", {done, error, busy}, 3'b100);
  endtask

  task automatic t_slow();
    clear_img();
    img[2] = 2; img[3] = 32'hFFFF_0000; img[4] = 32'hFFFF_FFFF; img[5] = 32'h0000_0001; img[6] = 0;
    launch(3);
    wait_end();
    check_stream(5, "slow");
    chk(done, "R6 done slow", done, 1);
  endtask

  task automatic t_zero_half();
    clear_img();
    img[2] = 0;
    launch(0);
    wait_end();
    check_stream(1, "zerohalf R8");
    chk(done && !error, "R6 zero length first", {done, error}, 2'b10);
  endtask

  task automatic t_busy_start();
    clear_img();
    img[2] = 1; img[3] = 32'h0000_0100; img[4] = 32'hCAFE_F00D; img[5] = 0;
    launch(2);
    repeat (150) @(negedge clk);
    half_period = 4'd5;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_end();
    check_stream(4, "busystart R9");
    chk(done && !busy, "R9 stream completed once", {done, busy}, 2'b10);
  endtask

  task automatic t_overflow();
    clear_img();
    img[2] = 12; img[3] = 32'h0000_0200;
    for (int i = 4; i < DEPTH; i++) img[i] = 32'h5A00_0000 + i;
    launch(1);
    wait_end();
    check_stream(14, "overflow");
    chk(error && !done && !busy, "R10 error stop", {error, done, busy}, 3'b100);
    repeat (20) @(negedge clk);
    chk(rx_n == 14 && !ser_clk && !ser_frame, "R10 nothing more sent", rx_n, 14);
  endtask

  initial begin
    clear_img();
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_slow();
    t_zero_half();
    t_busy_start();
    t_overflow();
    t_basic();
    chk(!error, "R6 error cleared by new start", error, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule